// File: doc/BRIEF.md
# Windowed Pixel Address Counter

This block produces the write position for a frame buffer of 240 columns by 432 rows, each pixel 18 bits wide. The host sets a starting column and row with a load pulse. After that, every pixel write pulse moves the position by one step. The step follows a rectangular window given by four bound inputs, so the host can refresh a sub-region of the picture without touching the rest of the buffer.

Three control bits shape the scan:
- One bit picks the column direction.
- One bit picks the row direction.
- One bit picks which axis moves fastest.

When the fast axis reaches the window edge in its direction of travel, it jumps back to the opposite edge and the slow axis moves one step. When both axes are at their edges, the position returns to the window's starting corner. The block also gives the current position as a linear buffer address.

Top module: `pix_window_ctr`

## Requirements
- R1: While reset is active, and after it is released, the position is column 0, row 0 and `lin_addr` is 0.
- R2: A cycle with `load` high sets the position to (`load_x`, `load_y`) at the next clock edge. This holds even if the window is invalid, and it takes priority over a `px_wr` in the same cycle.
- R3: Column is the fast axis when `vert_fast`=0. A `px_wr` with a valid window then moves the column by +1 if `x_down`=0, or by -1 if `x_down`=1, as long as the column is not at its edge. The row does not change.
- R4: Column is the fast axis and it is at its edge. The edge is `win_x_hi` when counting up and `win_x_lo` when counting down. A `px_wr` then sets the column to the opposite bound and moves the row one step in the direction given by `y_down` (0 = up, 1 = down).
- R5: With `vert_fast`=1 the row is the fast axis and the column is the slow axis. The row steps, wraps at its edge and advances the column in the same way as described in R3 and R4.
- R6: If both axes are at their edges when a `px_wr` arrives, the position goes to the starting corner of the window. The starting column is `win_x_lo` when counting up and `win_x_hi` when counting down. The starting row is chosen the same way from `win_y_lo` and `win_y_hi`.
- R7: `lin_addr` always equals row × 240 + column of the current position, with no added latency.
- R8: `win_bad` is high whenever any of these holds: `win_x_lo` > `win_x_hi`, `win_y_lo` > `win_y_hi`, `win_x_hi` > 239, or `win_y_hi` > 431. While it is high, `px_wr` leaves the position unchanged.
- R9: In a cycle where neither `load` nor `px_wr` is high, the position holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_x_lo | input | 8 | Window left column |
| win_x_hi | input | 8 | Window right column |
| win_y_lo | input | 9 | Window top row |
| win_y_hi | input | 9 | Window bottom row |
| x_down | input | 1 | Column direction, 1 = decrement |
| y_down | input | 1 | Row direction, 1 = decrement |
| vert_fast | input | 1 | 1 = row is the fast axis |
| load | input | 1 | Position load strobe |
| load_x | input | 8 | Column value to load |
| load_y | input | 9 | Row value to load |
| px_wr | input | 1 | Pixel write strobe, one step per cycle |
| cur_x | output | 8 | Current column |
| cur_y | output | 9 | Current row |
| lin_addr | output | 17 | Linear buffer address |
| win_bad | output | 1 | Window bounds invalid |

## Verification
Every stored bit of this block is visible on `cur_x` and `cur_y`. A wrong step, wrap or hold therefore shows up on the ports one clock edge after the write pulse that caused it. It also shows at once on `lin_addr`, which is a pure function of the position. The tests walk full scans of small windows in every direction and with both fast-axis choices, so a bad edge or corner decision is seen exactly at the pixel where the scan turns the corner. Invalid windows are checked by issuing writes and then observing that the position has not moved.

// File: rtl/pix_window_ctr.sv
module pix_window_ctr #(
  parameter int H_RES = 240,
  parameter int V_RES = 432,
  localparam int XW = $clog2(H_RES),
  localparam int YW = $clog2(V_RES),
  localparam int AW = $clog2(H_RES * V_RES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] win_x_lo,
  input  logic [XW-1:0] win_x_hi,
  input  logic [YW-1:0] win_y_lo,
  input  logic [YW-1:0] win_y_hi,
  input  logic          x_down,
  input  logic          y_down,
  input  logic          vert_fast,
  input  logic          load,
  input  logic [XW-1:0] load_x,
  input  logic [YW-1:0] load_y,
  input  logic          px_wr,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output logic [AW-1:0] lin_addr,
  output logic          win_bad
);

  logic          x_edge, y_edge;
  logic [XW-1:0] x_first, x_step, nx;
  logic [YW-1:0] y_first, y_step, ny;

  assign win_bad = (win_x_lo > win_x_hi) || (win_y_lo > win_y_hi) ||
                   (int'(win_x_hi) >= H_RES) || (int'(win_y_hi) >= V_RES);

  assign x_edge  = x_down ? (cur_x <= win_x_lo) : (cur_x >= win_x_hi);
  assign y_edge  = y_down ? (cur_y <= win_y_lo) : (cur_y >= win_y_hi);
  assign x_first = x_down ? win_x_hi : win_x_lo;
  assign y_first = y_down ? win_y_hi : win_y_lo;
  assign x_step  = x_down ? cur_x - 1'b1 : cur_x + 1'b1;
  assign y_step  = y_down ? cur_y - 1'b1 : cur_y + 1'b1;

  always_comb begin
    nx = cur_x;
    ny = cur_y;
    if (!vert_fast) begin
      nx = x_edge ? x_first : x_step;
      if (x_edge) ny = y_edge ? y_first : y_step;
    end else begin
      ny = y_edge ? y_first : y_step;
      if (y_edge) nx = x_edge ? x_first : x_step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x <= '0;
      cur_y <= '0;
    end else if (load) begin
      cur_x <= load_x;
      cur_y <= load_y;
    end else if (px_wr && !win_bad) begin
      cur_x <= nx;
      cur_y <= ny;
    end
  end

  assign lin_addr = AW'(cur_y) * AW'(H_RES) + AW'(cur_x);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_x == $past(load_x)) && (cur_y == $past(load_y)));

  // R3
  x_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_wr && !load && !win_bad && !vert_fast && !x_down &&
     cur_x >= win_x_lo && cur_x < win_x_hi)
    |=> (cur_x == $past(cur_x) + 1'b1) && $stable(cur_y));

  // R4
  x_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_wr && !load && !win_bad && !vert_fast && !x_down && cur_x == win_x_hi)
    |=> cur_x == $past(win_x_lo));

  // R5
  y_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_wr && !load && !win_bad && vert_fast && !y_down &&
     cur_y >= win_y_lo && cur_y < win_y_hi)
    |=> (cur_y == $past(cur_y) + 1'b1) && $stable(cur_x));

  // R8
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_wr && !load && win_bad) |=> $stable(cur_x) && $stable(cur_y));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!px_wr && !load) |=> $stable(cur_x) && $stable(cur_y));

endmodule

// File: tb/sim_pix_window_ctr.sv
module sim_pix_window_ctr;
  logic clk = 0, rst_n = 0;
  logic [7:0] win_x_lo = 0, win_x_hi = 239, load_x = 0;
  logic [8:0] win_y_lo = 0, win_y_hi = 431, load_y = 0;
  logic x_down = 0, y_down = 0, vert_fast = 0, load = 0, px_wr = 0;
  logic [7:0] cur_x;
  logic [8:0] cur_y;
  logic [16:0] lin_addr;
  logic win_bad;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pix_window_ctr u0 (.*);

  task automatic chk_xy(string tag, int ex, int ey);
    n_chk++;
    if (cur_x != ex || cur_y != ey || lin_addr != ey * 240 + ex) begin
      n_fail++;
      $display("FAIL %s: got (%0d,%0d) addr %0d, expected (%0d,%0d) addr %0d",
               tag, cur_x, cur_y, lin_addr, ex, ey, ey * 240 + ex);
    end
  endtask

  task automatic chk_bad(string tag, bit e);
    n_chk++;
    if (win_bad != e) begin
      n_fail++;
      $display("FAIL %s: win_bad got %0d expected %0d", tag, win_bad, e);
    end
  endtask

  task automatic do_load(int x, int y);
    @(negedge clk); load = 1; load_x = 8'(x); load_y = 9'(y);
    @(negedge clk); load = 0;
  endtask

  task automatic do_wr(int n);
    @(negedge clk); px_wr = 1;
    repeat (n) @(negedge clk);
    px_wr = 0;
  endtask

  task automatic set_win(int xl, int xh, int yl, int yh);
    @(negedge clk);
    win_x_lo = 8'(xl); win_x_hi = 8'(xh); win_y_lo = 9'(yl); win_y_hi = 9'(yh);
  endtask

  task automatic t_reset;
    @(negedge clk); chk_xy("R1 during reset", 0, 0);
    rst_n = 1;
    @(negedge clk); chk_xy("R1 after reset", 0, 0);
    chk_bad("R8 full window valid", 0);
  endtask

  task automatic t_load;
    do_load(10, 20); chk_xy("R2 load", 10, 20);
    @(negedge clk); load = 1; px_wr = 1; load_x = 3; load_y = 7;
    @(negedge clk); load = 0; px_wr = 0;
    chk_xy("R2 load beats write", 3, 7);
  endtask

  task automatic t_x_up;
    set_win(5, 8, 2, 4); x_down = 0; y_down = 0; vert_fast = 0;
    do_load(5, 2);
    do_wr(3);  chk_xy("R3 x up steps", 8, 2);
    do_wr(1);  chk_xy("R4 x edge next row", 5, 3);
    do_wr(7);  chk_xy("R4 last pixel", 8, 4);
    do_wr(1);  chk_xy("R6 corner wrap up", 5, 2);
  endtask

  task automatic t_x_down;
    x_down = 1; y_down = 1;
    do_load(8, 4);
    do_wr(1);  chk_xy("R3 x down step", 7, 4);
    do_wr(3);  chk_xy("R4 x down edge row down", 8, 3);
    do_wr(7);  chk_xy("R4 down last pixel", 5, 2);
    do_wr(1);  chk_xy("R6 corner wrap down", 8, 4);
  endtask

  task automatic t_vert;
    x_down = 0; y_down = 0; vert_fast = 1;
    do_load(5, 2);
    do_wr(2);  chk_xy("R5 y fast steps", 5, 4);
    do_wr(1);  chk_xy("R5 y edge column step", 6, 2);
    do_wr(8);  chk_xy("R5 vertical last", 8, 4);
    do_wr(1);  chk_xy("R6 vertical corner", 5, 2);
    vert_fast = 0;
  endtask

  task automatic t_bad;
    set_win(9, 8, 2, 4); @(negedge clk); chk_bad("R8 x lo>hi", 1);
    do_wr(3); chk_xy("R8 hold on bad", 5, 2);
    do_load(6, 3); chk_xy("R2 load while bad", 6, 3);
    set_win(5, 240, 2, 4); @(negedge clk); chk_bad("R8 x hi out of range", 1);
    set_win(5, 8, 2, 432); @(negedge clk); chk_bad("R8 y hi out of range", 1);
    set_win(5, 8, 4, 2); @(negedge clk); chk_bad("R8 y lo>hi", 1);
    do_wr(2); chk_xy("R8 hold y bad", 6, 3);
  endtask

  task automatic t_idle;
    set_win(0, 239, 0, 431); @(negedge clk); chk_bad("R8 valid again", 0);
    repeat (5) @(negedge clk);
    chk_xy("R9 idle hold", 6, 3);
  endtask

  task automatic t_full;
    do_load(239, 431); chk_xy("R7 max address", 239, 431);
    do_wr(1); chk_xy("R6 full screen wrap", 0, 0);
    do_load(100, 50); chk_xy("R7 mid address", 100, 50);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset; t_load; t_x_up; t_x_down; t_vert; t_bad; t_idle; t_full;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule